// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the address for each beat of a four-beat burst into a synchronous SRAM. A load cycle captures the full external address. Its two lowest bits become the burst start, and the bits above them are held for the whole burst. Each later advance cycle moves the two-bit offset to the next beat.

The order of the beats is set by a static mode input. It can be a linear count that wraps within the four-beat block, or an exclusive-OR interleave of the start offset. An active-low clock enable stops every register, so a stalled cycle acts as a longer copy of the one before it. A flag marks the fourth beat of the sequence.

The memory array, the data path, chip selection and byte enables belong to the surrounding design.

Top module: `burst_addr_seq`

## Requirements
- R1: While the synchronous active-low reset is low at a rising clock edge, the state clears regardless of the clock enable: after that edge `burst_addr` is 0, `beat_ofs` is 0, `last_beat` is 0 and no burst is in progress.
- R2: A load cycle is a rising edge with `clk_en_n` low and `load_n` low. After it, `burst_addr` equals the `addr_in` sampled at that edge, `beat_ofs` equals `addr_in[1:0]`, and `last_beat` is 0.
- R3: With `order_il` = 0 (linear), the k-th beat after a load (k = 0..3) has offset (start + k) mod 4.
- R4: With `order_il` = 1 (interleaved), the k-th beat after a load has offset start XOR k.
- R5: The bits of `burst_addr` above bit 1 keep their load-cycle value through every advance. The offset never carries into them, and `addr_in` has no effect on them while advancing.
- R6: An advance taken while on the fourth beat returns to the first beat of the same sequence, which is the start offset again.
- R7: `last_beat` is 1 exactly while a burst is in progress and it is on its fourth beat (k = 3).
- R8: While `clk_en_n` is 1 at a rising edge, no state changes at that edge, even if `load_n` is low.
- R9: An advance cycle (`clk_en_n` low, `load_n` high) with no burst in progress since reset leaves the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock enable; high freezes all state |
| load_n | input | 1 | Low: load a new address; high: advance the burst |
| order_il | input | 1 | Static order select: 1 interleaved, 0 linear |
| addr_in | input | ADDR_W (19) | External address, sampled on load cycles |
| burst_addr | output | ADDR_W (19) | Held upper bits joined with the current beat offset |
| beat_ofs | output | BEAT_BITS (2) | Current beat offset |
| last_beat | output | 1 | High on the fourth beat of the burst |

## Verification
Two situations are hard to reach from the ports. The first is an advance while on the fourth beat, where the wrap has to come back to the start offset and must not ripple into the held upper bits. The second is an advance issued before any load, which must not start a phantom burst. The stimulus table reaches the wrap in both orders, using starts whose linear path crosses offset 3 to 0. It sets `addr_in` to all ones on advance cycles, so any carry or leak into the upper bits shows up. Directed steps issue advances right after reset, reset in the middle of a burst while the clock enable is high, and try a load while the clock is frozen.

// File: rtl/burst_seq_pkg.sv
// Package: shared types for the burst address sequencer.
// Assumes: the order select is static during a burst.
package burst_seq_pkg;

    // Beat ordering selected by the static mode input.
    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;

    // Per-cycle operation decoded from the control inputs.
    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_LOAD = 2'd1,
        OP_STEP = 2'd2
    } seq_op_e;

endpackage

// File: rtl/burst_op_decode.sv
// Module: burst_op_decode
// Turns the clock enable and the advance/load control into one operation
// per cycle. Assumes: an advance only counts while a burst is in progress.
module burst_op_decode
    import burst_seq_pkg::*;
(
    input  logic    clk_en_n,
    input  logic    load_n,
    input  logic    act,
    output seq_op_e op
);

    // Pick load, step or idle for the current edge.
    always_comb begin
        op = OP_IDLE;
        if (!clk_en_n) begin
            if (!load_n) begin
                op = OP_LOAD;
            end else if (act) begin
                op = OP_STEP;
            end
        end
    end

endmodule

// File: rtl/burst_state_reg.sv
// Module: burst_state_reg
// Holds the captured upper address bits, the start offset, the beat count
// and the burst-active flag. Assumes: synchronous active-low reset that takes
// priority over every operation.
module burst_state_reg
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W    = 19,
    parameter int BEAT_BITS = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  seq_op_e                     op,
    input  logic [ADDR_W-1:0]           addr_in,
    output logic [ADDR_W-BEAT_BITS-1:0] upper_q,
    output logic [BEAT_BITS-1:0]        start_q,
    output logic [BEAT_BITS-1:0]        cnt_q,
    output logic                        act_q
);

    localparam int UP_W = ADDR_W - BEAT_BITS;

    // Capture on load, count on step, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_q <= '0;
            start_q <= '0;
            cnt_q   <= '0;
            act_q   <= 1'b0;
        end else begin
            case (op)
                OP_LOAD: begin
                    upper_q <= addr_in[ADDR_W-1:BEAT_BITS];
                    start_q <= addr_in[BEAT_BITS-1:0];
                    cnt_q   <= '0;
                    act_q   <= 1'b1;
                end
                OP_STEP: begin
                    cnt_q <= cnt_q + BEAT_BITS'(1);
                end
                default: begin
                end
            endcase
        end
    end

    logic [UP_W-1:0] unused_w;
    assign unused_w = upper_q;

endmodule

// File: rtl/burst_order_map.sv
// Module: burst_order_map
// Maps the start offset and beat count to the beat offset in linear or
// interleaved order, and flags the final beat. Pure combinational logic.
// Assumes: the count wraps naturally at 2**BEAT_BITS.
module burst_order_map
    import burst_seq_pkg::*;
#(
    parameter int BEAT_BITS = 2
) (
    input  logic [BEAT_BITS-1:0] start,
    input  logic [BEAT_BITS-1:0] cnt,
    input  logic                 act,
    input  burst_order_e         order,
    output logic [BEAT_BITS-1:0] ofs,
    output logic                 last
);

    localparam logic [BEAT_BITS-1:0] LAST_CNT = '1;

    logic [BEAT_BITS-1:0] lin_ofs;
    logic [BEAT_BITS-1:0] il_ofs;

    // Linear order: modular add within the burst block.
    assign lin_ofs = start + cnt;

    // Interleaved order: one XOR per offset bit.
    for (genvar i = 0; i < BEAT_BITS; i++) begin : g_il_bit
        assign il_ofs[i] = start[i] ^ cnt[i];
    end

    // Select the order and flag the final beat.
    always_comb begin
        ofs  = (order == ORD_INTERLEAVE) ? il_ofs : lin_ofs;
        last = act && (cnt == LAST_CNT);
    end

endmodule

// File: rtl/burst_addr_seq.sv
// Module: burst_addr_seq (top)
// Burst address sequencer: loads an address, then steps the low offset bits
// through a four-beat burst while the upper bits stay fixed.
// Assumes: order_il does not change during a burst.
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W    = 19,
    parameter int BEAT_BITS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clk_en_n,
    input  logic                 load_n,
    input  logic                 order_il,
    input  logic [ADDR_W-1:0]    addr_in,
    output logic [ADDR_W-1:0]    burst_addr,
    output logic [BEAT_BITS-1:0] beat_ofs,
    output logic                 last_beat
);

    localparam int UP_W = ADDR_W - BEAT_BITS;

    seq_op_e              op;
    logic                 act_q;
    logic [UP_W-1:0]      upper_q;
    logic [BEAT_BITS-1:0] start_q;
    logic [BEAT_BITS-1:0] cnt_q;
    logic [BEAT_BITS-1:0] ofs;
    burst_order_e         order;

    // Cast the static mode pin into the order type.
    assign order = burst_order_e'(order_il);

    burst_op_decode u_dec (
        .clk_en_n (clk_en_n),
        .load_n   (load_n),
        .act      (act_q),
        .op       (op)
    );

    burst_state_reg #(
        .ADDR_W    (ADDR_W),
        .BEAT_BITS (BEAT_BITS)
    ) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .addr_in (addr_in),
        .upper_q (upper_q),
        .start_q (start_q),
        .cnt_q   (cnt_q),
        .act_q   (act_q)
    );

    burst_order_map #(
        .BEAT_BITS (BEAT_BITS)
    ) u_map (
        .start (start_q),
        .cnt   (cnt_q),
        .act   (act_q),
        .order (order),
        .ofs   (ofs),
        .last  (last_beat)
    );

    // Join the held upper bits with the current beat offset.
    assign burst_addr = {upper_q, ofs};
    assign beat_ofs   = ofs;

endmodule

// File: rtl/burst_addr_seq_chk.sv
// Module: burst_addr_seq_chk
// Property checker bound into burst_addr_seq. Observes ports and the
// burst-active flag. Assumes: order_il is static while checked steps occur.
module burst_addr_seq_chk #(
    parameter int ADDR_W    = 19,
    parameter int BEAT_BITS = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 clk_en_n,
    input logic                 load_n,
    input logic                 order_il,
    input logic [ADDR_W-1:0]    addr_in,
    input logic [ADDR_W-1:0]    burst_addr,
    input logic [BEAT_BITS-1:0] beat_ofs,
    input logic                 last_beat,
    input logic                 act
);

    // Reset clears offset and flag.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (beat_ofs == '0 && !last_beat && burst_addr == '0));

    // Load captures the whole address.
    assert_load_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !load_n) |=> (burst_addr == $past(addr_in) && !last_beat));

    // Linear order steps by one, mod the burst length.
    assert_linear_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && load_n && act && !order_il)
        |=> (order_il || beat_ofs == BEAT_BITS'($past(beat_ofs) + 1'b1)));

    // Upper bits hold across advance and stall cycles.
    assert_upper_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en_n || load_n)
        |=> burst_addr[ADDR_W-1:BEAT_BITS] == $past(burst_addr[ADDR_W-1:BEAT_BITS]));

    // A step from the last beat clears the flag.
    assert_wrap_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && load_n && last_beat) |=> !last_beat);

    // The flag only appears inside a burst.
    assert_last_in_burst_R7: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat |-> act);

    // A stalled clock keeps every output.
    assert_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> (!$stable(order_il) ||
                      ($stable(burst_addr) && $stable(last_beat))));

    // No burst in progress: advance changes nothing.
    assert_idle_advance_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && load_n && !act) |=> ($stable(burst_addr) && !last_beat));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(
    .ADDR_W    (ADDR_W),
    .BEAT_BITS (BEAT_BITS)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_en_n   (clk_en_n),
    .load_n     (load_n),
    .order_il   (order_il),
    .addr_in    (addr_in),
    .burst_addr (burst_addr),
    .beat_ofs   (beat_ofs),
    .last_beat  (last_beat),
    .act        (act_q)
);

// File: tb/burst_addr_seq_tb_top.sv
// Testbench for burst_addr_seq: a table of vectors walked by one loop, then
// directed reset and corner-case steps. Drives on the falling edge and
// samples 1 ns after the rising edge.
module burst_addr_seq_tb_top;

    localparam int AW = 19;
    localparam int BB = 2;
    localparam time HALF = 2ns;

    typedef struct packed {
        logic          ce_n;
        logic          ld_n;
        logic          il;
        logic [AW-1:0] a;
        logic [AW-1:0] ea;
        logic          el;
        logic [3:0]    req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 1'b0, 19'h7FFFF, 19'h00000, 1'b0, 4'd9}, // R9 advance before any load
        '{1'b0, 1'b0, 1'b0, 19'h12346, 19'h12346, 1'b0, 4'd2}, // R2 load linear, start 2
        '{1'b0, 1'b1, 1'b0, 19'h7FFFF, 19'h12347, 1'b0, 4'd3}, // R3 beat 1
        '{1'b0, 1'b1, 1'b0, 19'h7FFFF, 19'h12344, 1'b0, 4'd5}, // R5 3->0 with no carry
        '{1'b0, 1'b1, 1'b0, 19'h7FFFF, 19'h12345, 1'b1, 4'd7}, // R7 fourth beat
        '{1'b0, 1'b1, 1'b0, 19'h7FFFF, 19'h12346, 1'b0, 4'd6}, // R6 wrap to start
        '{1'b1, 1'b0, 1'b0, 19'h00001, 19'h12346, 1'b0, 4'd8}, // R8 load under stall ignored
        '{1'b0, 1'b0, 1'b1, 19'h0ABC1, 19'h0ABC1, 1'b0, 4'd2}, // R2 load interleaved, start 1
        '{1'b0, 1'b1, 1'b1, 19'h7FFFF, 19'h0ABC0, 1'b0, 4'd4}, // R4 1^1
        '{1'b0, 1'b1, 1'b1, 19'h7FFFF, 19'h0ABC3, 1'b0, 4'd4}, // R4 1^2
        '{1'b0, 1'b1, 1'b1, 19'h7FFFF, 19'h0ABC2, 1'b1, 4'd7}, // R7 1^3 last
        '{1'b1, 1'b1, 1'b1, 19'h7FFFF, 19'h0ABC2, 1'b1, 4'd8}, // R8 stall keeps last beat
        '{1'b0, 1'b1, 1'b1, 19'h7FFFF, 19'h0ABC1, 1'b0, 4'd6}, // R6 interleaved wrap
        '{1'b0, 1'b0, 1'b0, 19'h40003, 19'h40003, 1'b0, 4'd2}, // R2 load linear, start 3
        '{1'b0, 1'b1, 1'b0, 19'h00000, 19'h40000, 1'b0, 4'd5}, // R5 upper held
        '{1'b0, 1'b1, 1'b0, 19'h00000, 19'h40001, 1'b0, 4'd3}, // R3 beat 2
        '{1'b0, 1'b1, 1'b0, 19'h00000, 19'h40002, 1'b1, 4'd7}, // R7 last
        '{1'b0, 1'b0, 1'b1, 19'h55552, 19'h55552, 1'b0, 4'd2}, // R2 reload, start 2
        '{1'b0, 1'b1, 1'b1, 19'h7FFFF, 19'h55553, 1'b0, 4'd4}, // R4 2^1
        '{1'b0, 1'b1, 1'b1, 19'h7FFFF, 19'h55550, 1'b0, 4'd4}, // R4 2^2
        '{1'b0, 1'b1, 1'b1, 19'h7FFFF, 19'h55551, 1'b1, 4'd7}  // R7 2^3 last
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          clk_en_n;
    logic          load_n;
    logic          order_il;
    logic [AW-1:0] addr_in;
    logic [AW-1:0] burst_addr;
    logic [BB-1:0] beat_ofs;
    logic          last_beat;

    int n_checks = 0;
    int n_errs   = 0;
    bit finished = 1'b0;

    always #HALF clk = ~clk;

    burst_addr_seq dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_en_n   (clk_en_n),
        .load_n     (load_n),
        .order_il   (order_il),
        .addr_in    (addr_in),
        .burst_addr (burst_addr),
        .beat_ofs   (beat_ofs),
        .last_beat  (last_beat)
    );

    // Compare all outputs against the expected address and flag.
    task automatic check_out(input string tag, input logic [AW-1:0] ea, input logic el);
        n_checks++;
        if (burst_addr !== ea || beat_ofs !== ea[BB-1:0] || last_beat !== el) begin
            n_errs++;
            $display("FAIL %s: addr=%h ofs=%0d last=%b expected addr=%h ofs=%0d last=%b",
                     tag, burst_addr, beat_ofs, last_beat, ea, ea[BB-1:0], el);
        end
    endtask

    // Apply one cycle of inputs and wait until just after the edge.
    task automatic step(input logic ce, input logic ld, input logic il, input logic [AW-1:0] a);
        @(negedge clk);
        clk_en_n = ce;
        load_n   = ld;
        order_il = il;
        addr_in  = a;
        @(posedge clk);
        #1ns;
    endtask

    initial begin
        rst_n    = 1'b0;
        clk_en_n = 1'b0;
        load_n   = 1'b1;
        order_il = 1'b0;
        addr_in  = '0;
        repeat (3) @(posedge clk);
        #1ns;
        check_out("R1 reset state", 19'h00000, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VECS[i].ce_n, VECS[i].ld_n, VECS[i].il, VECS[i].a);
            check_out($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].ea, VECS[i].el);
        end

        // R1: reset mid-burst on the last beat, with the clock stalled.
        @(negedge clk);
        rst_n = 1'b0;
        step(1'b1, 1'b1, 1'b1, 19'h7FFFF);
        check_out("R1 reset overrides stall", 19'h00000, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: repeated advances after reset stay idle.
        step(1'b0, 1'b1, 1'b0, 19'h7FFFF);
        check_out("R9 idle advance 1", 19'h00000, 1'b0);
        step(1'b0, 1'b1, 1'b0, 19'h7FFFF);
        step(1'b0, 1'b1, 1'b0, 19'h7FFFF);
        step(1'b0, 1'b1, 1'b0, 19'h7FFFF);
        check_out("R9 idle advance 4", 19'h00000, 1'b0);

        // R6: two full laps in linear order from start 0.
        step(1'b0, 1'b0, 1'b0, 19'h7FFFC);
        check_out("R2 load all-ones upper", 19'h7FFFC, 1'b0);
        for (int k = 1; k < 8; k++) begin
            step(1'b0, 1'b1, 1'b0, 19'h00000);
            check_out($sformatf("R6 lap beat %0d", k),
                      {17'h1FFFF, 2'(k)}, ((k % 4) == 3));
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(4ns * 100000);
        if (!finished) begin
            n_errs++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

endmodule